// File: doc/BRIEF.md
# Two-Level Interrupt Request Gate

This block collects the interrupt sources of a small controller core and reduces them to one request line. The core sources are a timer overflow pulse, an external pin with a selectable active edge, and a change detector on a small group of input pins. Beside them sits a group of peripheral sources, each arriving as a one-cycle event pulse. Every source owns a sticky flag and an enable bit. A global enable gates everything. A second, group-level enable gates only the peripheral group.

Software reaches the block through a byte-wide register port. A write strobe selects one of three registers. A registered read path returns the core control byte, the peripheral enable byte or the peripheral flag byte. The change detector compares the pins with a snapshot. A port-read strobe refreshes the snapshot, so software can end a mismatch before it clears the change flag.

Top module: `irq_gate_ctrl`

## Requirements
- R1: Register select encoding: 0 = core control byte, 1 = peripheral enable byte, 2 = peripheral flag byte, 3 = reads zero and ignores writes. `rd_data` shows the register selected by `rd_sel` one clock after the select is sampled.
- R2: Core control byte layout. Enables: global at bit 7, peripheral group at bit 6, timer at bit 5, external pin at bit 4, pin change at bit 3. Flags: timer at bit 2, external pin at bit 1, pin change at bit 0.
- R3: When the global enable is 0, `irq` stays 0 whatever the flags and other enables hold.
- R4: When the peripheral group enable is 0, no peripheral flag can raise `irq`, even with its own enable set. Core sources are unaffected.
- R5: `irq` equals global AND (any core flag with its enable OR (group enable AND any peripheral flag with its enable)). It is registered and appears one clock after the flags that cause it.
- R6: With `ext_rise_sel`=1, a 0-to-1 change of `ext_pin` between two clock samples sets the external flag. With `ext_rise_sel`=0, a 1-to-0 change sets it. A change in the other direction has no effect.
- R7: While any `chg_pins` bit differs from the snapshot, the pin-change flag is set on every clock, so a software clear does not stick.
- R8: A `port_rd` pulse copies `chg_pins` into the snapshot. This ends the mismatch, and a later clear of the pin-change flag holds.
- R9: A `tmr_ovf` pulse sets the timer flag.
- R10: Peripheral event bit i sets peripheral flag bit i. The bit order, 7 down to 0, is parallel port, A/D, receive, transmit, serial port, capture/compare 1, timer-2 match, timer-1 overflow. The enable byte uses the same order.
- R11: Flags are sticky. Only a write of that register changes them, and the written value replaces them. If a hardware set and a write of 0 hit the same flag in one clock, the flag ends up 1.
- R12: After reset, all enables, flags, the snapshot, `rd_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | 8 | Registered read data |
| ext_rise_sel | input | 1 | 1 = rising edge of ext_pin is active, 0 = falling |
| ext_pin | input | 1 | External interrupt pin (synchronous) |
| chg_pins | input | CHG_W | Pins watched for change |
| port_rd | input | 1 | Port read strobe, refreshes the pin snapshot |
| tmr_ovf | input | 1 | Timer overflow pulse |
| periph_evt | input | PERIPH_W | Peripheral event pulses |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench tries to clear the pin-change flag while the mismatch is still present. A design that let the clear stick would drop a pending change. It checks that the flag clears only after a port-read pulse, which catches a detector that compares against the wrong value. It toggles the external pin in the inactive direction under each edge setting, where a design with the edge polarity swapped would set a flag. It also writes a clear in the same clock as an event on the same flag; a design that let the write win would lose the event. Finally, it sets peripheral flags with the group enable off, where a design missing that gate would assert the request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] SEL_CORE  = 2'd0;
  localparam logic [1:0] SEL_PEN   = 2'd1;
  localparam logic [1:0] SEL_PFLAG = 2'd2;
  localparam int BYTE_W = 8;
  localparam int CORE_SRC = 3;
  localparam int BIT_GLOBAL = 7;
  localparam int BIT_GROUP  = 6;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin;
  end
  always_comb begin
    if (rise_sel) hit = pin & ~prev_q;
    else          hit = ~pin & prev_q;
  end
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic         snap_req,
  output logic         mismatch,
  output logic [W-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (rst)           snap_q <= '0;
    else if (snap_req) snap_q <= pins;
  end
  assign mismatch = (pins != snap_q);
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] flags_q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flags_q[i] <= 1'b0;
      else if (hw_set[i]) flags_q[i] <= 1'b1;
      else if (wr)        flags_q[i] <= wr_val[i];
    end
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_pkg::*;
#(
  parameter int PERIPH_W = 8,
  parameter int CHG_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [1:0]          rd_sel,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                ext_rise_sel,
  input  logic                ext_pin,
  input  logic [CHG_W-1:0]    chg_pins,
  input  logic                port_rd,
  input  logic                tmr_ovf,
  input  logic [PERIPH_W-1:0] periph_evt,
  output logic                irq
);
  localparam int EN_W = BYTE_W - CORE_SRC;

  logic                wr_core, wr_pen, wr_pflag;
  logic [EN_W-1:0]     core_en_q;
  logic [CORE_SRC-1:0] core_fl_q;
  logic [PERIPH_W-1:0] pen_q, pflag_q;
  logic [BYTE_W-1:0]   ctrl_byte;
  logic [CHG_W-1:0]    chg_snap;
  logic                ext_hit, chg_mis, irq_d;
  logic [BYTE_W-1:0]   pen_ext, pflag_ext, rd_d;

  assign wr_core  = wr_en && (wr_sel == SEL_CORE);
  assign wr_pen   = wr_en && (wr_sel == SEL_PEN);
  assign wr_pflag = wr_en && (wr_sel == SEL_PFLAG);

  irq_edge_det u_edge (
    .clk(clk), .rst(rst), .pin(ext_pin), .rise_sel(ext_rise_sel), .hit(ext_hit)
  );

  irq_chg_det #(.W(CHG_W)) u_chg (
    .clk(clk), .rst(rst), .pins(chg_pins), .snap_req(port_rd),
    .mismatch(chg_mis), .snap_q(chg_snap)
  );

  // core flags: bit2 timer, bit1 external pin, bit0 pin change
  irq_sticky_bank #(.W(CORE_SRC)) u_core_fl (
    .clk(clk), .rst(rst), .wr(wr_core), .wr_val(wr_data[CORE_SRC-1:0]),
    .hw_set({tmr_ovf, ext_hit, chg_mis}), .flags_q(core_fl_q)
  );

  irq_sticky_bank #(.W(PERIPH_W)) u_per_fl (
    .clk(clk), .rst(rst), .wr(wr_pflag), .wr_val(wr_data[PERIPH_W-1:0]),
    .hw_set(periph_evt), .flags_q(pflag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en_q <= '0;
      pen_q     <= '0;
    end else begin
      if (wr_core) core_en_q <= wr_data[BYTE_W-1:CORE_SRC];
      if (wr_pen)  pen_q     <= wr_data[PERIPH_W-1:0];
    end
  end

  assign ctrl_byte = {core_en_q, core_fl_q};

  // per-source enables at bits 5..3 line up with flags at bits 2..0
  assign irq_d = ctrl_byte[BIT_GLOBAL] &
                 ((|(ctrl_byte[2*CORE_SRC-1:CORE_SRC] & core_fl_q)) |
                  (ctrl_byte[BIT_GROUP] & (|(pen_q & pflag_q))));

  always_comb begin
    pen_ext   = '0;
    pflag_ext = '0;
    pen_ext[PERIPH_W-1:0]   = pen_q;
    pflag_ext[PERIPH_W-1:0] = pflag_q;
    case (rd_sel)
      SEL_CORE:  rd_d = ctrl_byte;
      SEL_PEN:   rd_d = pen_ext;
      SEL_PFLAG: rd_d = pflag_ext;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      irq     <= irq_d;
      rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int PERIPH_W = 8,
  parameter int CHG_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic                irq,
  input logic [7:0]          ctrl_byte,
  input logic [PERIPH_W-1:0] pen_q,
  input logic [PERIPH_W-1:0] pflag_q,
  input logic [CHG_W-1:0]    chg_pins,
  input logic [CHG_W-1:0]    chg_snap
);
  // R3
  global_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_byte[7]));

  // R4
  group_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && ($past(ctrl_byte[5:3] & ctrl_byte[2:0]) == 3'b000)) |-> $past(ctrl_byte[6]));

  // R11
  sticky_per_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(pflag_q) & ~pflag_q) != '0) |-> $past(wr_en && wr_sel == 2'd2));

  // R11
  sticky_core_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(ctrl_byte[2:0]) & ~ctrl_byte[2:0]) != 3'b000) |-> $past(wr_en && wr_sel == 2'd0));

  // R7
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(chg_pins != chg_snap) |-> ctrl_byte[0]);

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (($past(ctrl_byte[5:3] & ctrl_byte[2:0]) != 3'b000) || ($past(pen_q & pflag_q) != '0)));
endmodule

bind irq_gate_ctrl irq_gate_chk #(.PERIPH_W(PERIPH_W), .CHG_W(CHG_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .irq(irq),
  .ctrl_byte(ctrl_byte), .pen_q(pen_q), .pflag_q(pflag_q),
  .chg_pins(chg_pins), .chg_snap(chg_snap)
);

// File: tb/sim_irq_gate_ctrl.sv
module sim_irq_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {core ctrl byte, periph enable, periph event, expected irq}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h00, 8'hFF, 8'h01, 1'b0},
    {8'hC0, 8'h01, 8'h01, 1'b1},
    {8'h80, 8'h01, 8'h01, 1'b0},
    {8'hC0, 8'h02, 8'h01, 1'b0},
    {8'hA4, 8'h00, 8'h00, 1'b1},
    {8'h92, 8'h00, 8'h00, 1'b1},
    {8'h89, 8'h00, 8'h00, 1'b1},
    {8'h83, 8'h00, 8'h00, 1'b0},
    {8'hC0, 8'h80, 8'h80, 1'b1},
    {8'h40, 8'hFF, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic ext_rise_sel = 1'b1;
  logic ext_pin = 1'b0;
  logic [3:0] chg_pins = 4'h0;
  logic port_rd = 1'b0;
  logic tmr_ovf = 1'b0;
  logic [7:0] periph_evt = 8'h00;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gate_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ext_rise_sel(ext_rise_sel),
    .ext_pin(ext_pin), .chg_pins(chg_pins), .port_rd(port_rd),
    .tmr_ovf(tmr_ovf), .periph_evt(periph_evt), .irq(irq)
  );

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
    rd_sel = s;
    cyc();
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst = 1'b0;
    // R12 reset state
    chk("R12 irq", {7'd0, irq}, 8'h00);
    rd_chk("R12 core", 2'd0, 8'h00);
    rd_chk("R12 pen", 2'd1, 8'h00);
    rd_chk("R12 pflag", 2'd2, 8'h00);

    // vector table: R2 R3 R4 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, VEC[i][24:17]);
      wr(2'd1, VEC[i][16:9]);
      wr(2'd2, 8'h00);
      periph_evt = VEC[i][8:1];
      cyc();
      periph_evt = 8'h00;
      rd_chk("R10 pflag", 2'd2, VEC[i][8:1]);
      chk("R5 irq", {7'd0, irq}, {7'd0, VEC[i][0]});
      rd_chk("R1 pen", 2'd1, VEC[i][16:9]);
    end
    wr(2'd2, 8'h00);

    // R1 select 3 reads zero and writes are ignored
    wr(2'd3, 8'hFF);
    rd_chk("R1 sel3", 2'd3, 8'h00);

    // R9 timer overflow with global disabled
    wr(2'd0, 8'h20);
    tmr_ovf = 1'b1; cyc(); tmr_ovf = 1'b0;
    rd_chk("R9 timer flag", 2'd0, 8'h24);
    chk("R3 no irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hA4);
    cyc();
    chk("R5 timer irq", {7'd0, irq}, 8'h01);

    // R6 external edge selection
    wr(2'd0, 8'h90);
    ext_rise_sel = 1'b1;
    ext_pin = 1'b1; cyc();
    rd_chk("R6 rise sets", 2'd0, 8'h92);
    chk("R6 irq", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h90);
    ext_pin = 1'b0; cyc();
    rd_chk("R6 fall ignored", 2'd0, 8'h90);
    ext_rise_sel = 1'b0;
    ext_pin = 1'b1; cyc();
    rd_chk("R6 rise ignored", 2'd0, 8'h90);
    ext_pin = 1'b0; cyc();
    rd_chk("R6 fall sets", 2'd0, 8'h92);

    // R7 R8 pin change
    wr(2'd0, 8'h88);
    chg_pins = 4'h5; cyc();
    rd_chk("R7 change sets", 2'd0, 8'h89);
    wr(2'd0, 8'h88);
    rd_chk("R7 clear fails", 2'd0, 8'h89);
    port_rd = 1'b1; cyc(); port_rd = 1'b0;
    wr(2'd0, 8'h88);
    rd_chk("R8 clear sticks", 2'd0, 8'h88);
    chk("R8 irq low", {7'd0, irq}, 8'h00);

    // R11 set wins over clear in the same clock
    wr(2'd2, 8'h00);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00; periph_evt = 8'h04;
    cyc();
    wr_en = 1'b0; periph_evt = 8'h00;
    rd_chk("R11 set wins", 2'd2, 8'h04);
    cyc(); cyc();
    rd_chk("R11 sticky", 2'd2, 8'h04);
    wr(2'd2, 8'h00);
    rd_chk("R11 cleared", 2'd2, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule